// File: doc/BRIEF.md
# Addressed Serial Channel-Code Register Port

This block receives fixed-length serial words over a three-wire link: a serial clock, a serial data line, and a load line that frames the word. Each word is 16 bits long. It carries a 4-bit device tag, a 4-bit channel index and an 8-bit code. Serial bits are shifted in only while the load line is high.

When the load line drops, the block checks the tag against four strap inputs that set this instance's device address. On a match, it writes the code into one of eight channel registers. The eight registers drive a converter that lies outside this block. Each holds an unsigned code D, and the analog stage downstream scales its reference by D/256.

The bit leaving the top of the shift register is presented on a serial output, so that devices can be daisy-chained or can share one readback wire. An enable qualifies this output and is high only while the load line is high. An asynchronous active-low reset returns every channel to midscale.

All registers run on one free-running system clock, `clk`. The serial clock and the load line are sampled on that clock, and their edges are found by comparing each input with its registered copy.

Top module: `chain_dac_port`

## Requirements
- R1: While `rst_n` is low, every channel code is 0x80 and the shift register holds zero, so the first serial output bit after reset is 0.
- R2: Serial bits enter MSB first. The word is tag[3:0], then channel[3:0], then code[7:0], so the first bit shifted in is tag bit 3 and the last is code bit 0.
- R3: One bit of `sdi` is shifted in at the first `clk` edge that samples `sclk` high after sampling it low, provided `load` is high at that edge.
- R4: At the first `clk` edge that samples `load` low after sampling it high, the received code is written into the addressed channel if the tag equals `chip_addr` and the channel index is 0 to 7. The new value appears on `codes_o` right after that edge, and at most one channel changes.
- R5: A word whose tag differs from `chip_addr` changes no channel.
- R6: Channel indices 8 to 15 change no channel.
- R7: While `load` is low, `sclk` and `sdi` have no effect on the shift register.
- R8: `sdo_oe` is high exactly while `load` is high. Outside that window the serial output is to be treated as high impedance.
- R9: `sdo` always shows the current top bit of the shift register. After a full word has been shifted in, the next 16 shifts present that word on `sdo`, MSB first, one bit per shift.
- R10: A write happens only on a `load` fall that follows at least one shift while `load` was high. A load pulse with no shifts, or `load` held low, writes nothing.
- R11: Driving `rst_n` low sets all channels to 0x80 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; its rising edge is detected on `clk` |
| sdi | input | 1 | Serial data in |
| load | input | 1 | Frames shifting while high; a falling edge commits the word |
| chip_addr | input | 4 | Strap-set device address, compared with the tag |
| sdo | output | 1 | Serial data out: top bit of the shift register |
| sdo_oe | output | 1 | Output enable for `sdo`, drives the pad tri-state |
| codes_o | output | 64 | Eight channel codes; channel i occupies bits [8i+7:8i] |

## Verification
A shift takes effect at the one `clk` edge that first samples `sclk` high. The new top bit is therefore valid on `sdo` at the following falling edge of `clk`, and the bench samples `sdo` there, before it raises `sclk` for the next bit. A commit lands at the edge that first samples `load` low, so the channel codes are compared at the falling edge right after `load` is dropped. `sdo_oe` follows `load` without a register and is checked one nanosecond after `load` changes. The asynchronous reset is checked within the same clock phase in which it is asserted, before any rising edge arrives.

// File: rtl/chdac_pkg.sv
package chdac_pkg;
  localparam int DEF_TAG_W  = 4;
  localparam int DEF_ADDR_W = 4;
  localparam int DEF_CODE_W = 8;
  localparam int DEF_N_CH   = 8;

  // Midscale of an unsigned code of width w: only the top bit set.
  function automatic logic [31:0] mid_of(input int w);
    return 32'd1 << (w - 1);
  endfunction

  // True when a received channel index names an existing channel.
  function automatic logic index_valid(input int idx, input int n_ch);
    return (idx >= 0) && (idx < n_ch);
  endfunction
endpackage

// File: rtl/cdp_frame_shifter.sv
module cdp_frame_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               sdi_i,
  input  logic               load_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               commit_o,
  output logic               load_q_o,
  output logic               sdo_o
);
  logic               sclk_q;
  logic               load_q;
  logic               armed;
  logic [FRAME_W-1:0] sreg;
  logic               shift_evt;
  logic               fall_evt;

  assign shift_evt = load_i && sclk_i && !sclk_q;
  assign fall_evt  = load_q && !load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      load_q <= 1'b0;
      armed  <= 1'b0;
      sreg   <= '0;
    end else begin
      sclk_q <= sclk_i;
      load_q <= load_i;
      if (shift_evt) begin
        sreg  <= {sreg[FRAME_W-2:0], sdi_i};
        armed <= 1'b1;
      end else if (fall_evt) begin
        armed <= 1'b0;
      end
    end
  end

  assign frame_o  = sreg;
  assign commit_o = fall_evt && armed;
  assign load_q_o = load_q;
  assign sdo_o    = sreg[FRAME_W-1];

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(sreg)); // R7
  AST_SHIFT_MOVES_UP: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (sreg[FRAME_W-1:1] == $past(sreg[FRAME_W-2:0]))); // R2
  AST_SHIFT_TAKES_SDI: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (sreg[0] == $past(sdi_i))); // R3
endmodule

// File: rtl/cdp_chan_select.sv
module cdp_chan_select #(
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 4,
  parameter int N_CH   = 8
) (
  input  logic              commit_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [TAG_W-1:0]  chip_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_CH-1:0]   wr_en_o
);
  logic tag_hit;

  assign tag_hit = (tag_i == chip_addr_i);

  // One comparator per channel; indices at or above N_CH match none.
  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    assign wr_en_o[i] = commit_i && tag_hit && (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/cdp_code_bank.sv
module cdp_code_bank #(
  parameter int N_CH   = 8,
  parameter int CODE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        wr_en_i,
  input  logic [CODE_W-1:0]      code_i,
  output logic [N_CH*CODE_W-1:0] codes_o
);
  import chdac_pkg::*;

  localparam logic [CODE_W-1:0] MID = CODE_W'(mid_of(CODE_W));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          code_q <= MID;
      else if (wr_en_i[i]) code_q <= code_i;
    end
    assign codes_o[i*CODE_W +: CODE_W] = code_q;
  end
endmodule

// File: rtl/chain_dac_port.sv
module chain_dac_port #(
  parameter int TAG_W  = chdac_pkg::DEF_TAG_W,
  parameter int ADDR_W = chdac_pkg::DEF_ADDR_W,
  parameter int CODE_W = chdac_pkg::DEF_CODE_W,
  parameter int N_CH   = chdac_pkg::DEF_N_CH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk,
  input  logic                   sdi,
  input  logic                   load,
  input  logic [TAG_W-1:0]       chip_addr,
  output logic                   sdo,
  output logic                   sdo_oe,
  output logic [N_CH*CODE_W-1:0] codes_o
);
  import chdac_pkg::*;

  localparam int FRAME_W = TAG_W + ADDR_W + CODE_W;

  logic [FRAME_W-1:0] frame;
  logic               commit;
  logic               load_q;
  logic [TAG_W-1:0]   rx_tag;
  logic [ADDR_W-1:0]  rx_addr;
  logic [CODE_W-1:0]  rx_code;
  logic [N_CH-1:0]    wr_en;

  cdp_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_i   (sclk),
    .sdi_i    (sdi),
    .load_i   (load),
    .frame_o  (frame),
    .commit_o (commit),
    .load_q_o (load_q),
    .sdo_o    (sdo)
  );

  // Word layout, MSB first: tag, channel index, code.
  assign rx_tag  = frame[FRAME_W-1 -: TAG_W];
  assign rx_addr = frame[CODE_W +: ADDR_W];
  assign rx_code = frame[CODE_W-1:0];

  cdp_chan_select #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .N_CH(N_CH)) u_sel (
    .commit_i    (commit),
    .tag_i       (rx_tag),
    .chip_addr_i (chip_addr),
    .addr_i      (rx_addr),
    .wr_en_o     (wr_en)
  );

  cdp_code_bank #(.N_CH(N_CH), .CODE_W(CODE_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .code_i  (rx_code),
    .codes_o (codes_o)
  );

  assign sdo_oe = load;

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en)); // R4
  AST_NO_WRITE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> $stable(codes_o)); // R4
  AST_NO_REPEAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !load_q) |=> $stable(codes_o)); // R10
  AST_FOREIGN_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (rx_tag != chip_addr)) |=> $stable(codes_o)); // R5
  AST_HIGH_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !index_valid(int'(rx_addr), N_CH)) |=> $stable(codes_o)); // R6
endmodule

// File: tb/test_chain_dac_port.sv
module test_chain_dac_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk, sdi, load;
  logic [3:0]  chip_addr;
  logic        sdo, sdo_oe;
  logic [63:0] codes_o;

  int tests = 0;
  int fails = 0;
  logic [7:0] model [8];

  always #4 clk = ~clk;

  chain_dac_port i_chain_dac_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .load(load),
    .chip_addr(chip_addr), .sdo(sdo), .sdo_oe(sdo_oe), .codes_o(codes_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_codes(input string req);
    for (int c = 0; c < 8; c++) begin
      check(codes_o[c*8 +: 8] == model[c], req, codes_o[c*8 +: 8], model[c]);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 8; c++) model[c] = 8'h80;
  endtask

  // Called at a falling clk edge; returns at a falling clk edge.
  task automatic shift_bit(input logic b);
    sdi  = b;
    sclk = 1'b1;
    @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic shift_word(input logic [15:0] w, input logic [15:0] seen, input bit chk);
    for (int i = 15; i >= 0; i--) begin
      if (chk) check(sdo == seen[i], "R9 sdo bit", sdo, seen[i]);
      shift_bit(w[i]);
    end
  endtask

  // Sends tag, index, code and drops load; codes are settled on return.
  task automatic send_word(input logic [3:0] tag, input logic [3:0] idx, input logic [7:0] code);
    load = 1'b1;
    @(negedge clk);
    shift_word({tag, idx, code}, 16'h0, 1'b0);
    load = 1'b0;
    @(negedge clk);
    if (tag == chip_addr && idx < 8) model[idx] = code;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0; load = 1'b0; chip_addr = 4'h9;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R8 enable follows load
    check_codes("R1 reset codes");
    check(sdo_oe == 1'b0, "R8 oe low idle", sdo_oe, 0);
    load = 1'b1;
    #1;
    check(sdo_oe == 1'b1, "R8 oe high in load", sdo_oe, 1);
    check(sdo == 1'b0, "R1 cleared shift reg", sdo, 0);
    @(negedge clk);
    load = 1'b0;
    #1;
    check(sdo_oe == 1'b0, "R8 oe low after load", sdo_oe, 0);
    @(negedge clk);
    check_codes("R10 no shift no write");

    // R2 R3 R4 R6: sweep every channel index with a matching tag
    for (int a = 0; a < 16; a++) begin
      send_word(4'h9, 4'(a), 8'((a * 29 + 7) & 255));
      check_codes(a < 8 ? "R4 indexed write" : "R6 index out of range");
    end

    // R5: sweep every tag against a fixed strap value
    for (int t = 0; t < 16; t++) begin
      send_word(4'(t), 4'(t % 8), 8'((t * 13 + 100) & 255));
      check_codes(t == 9 ? "R4 tag match" : "R5 tag mismatch");
    end

    // R4: sweep every strap value with its own tag
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      chip_addr = 4'(s);
      send_word(4'(s), 4'(s % 8), 8'(s) ^ 8'h5A);
      check_codes("R4 strap sweep");
    end

    // R7 R9: toggle while idle, then read the last word back on sdo
    chip_addr = 4'h9;
    send_word(4'h9, 4'h2, 8'hC3);
    check_codes("R4 write before readback");
    for (int k = 0; k < 20; k++) begin
      sdi  = ~k[0];
      sclk = 1'b1;
      @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
    end
    check_codes("R7 idle toggles");
    load = 1'b1;
    @(negedge clk);
    shift_word(16'h0000, {4'h9, 4'h2, 8'hC3}, 1'b1);
    check(sdo == 1'b0, "R9 zeros follow", sdo, 0);
    load = 1'b0;
    @(negedge clk);
    check_codes("R5 zero word foreign tag");

    // R10: mismatched word, then strap changed to match, empty load pulse
    chip_addr = 4'hA;
    send_word(4'h5, 4'h1, 8'h3C);
    check_codes("R5 mismatch before empty pulse");
    chip_addr = 4'h5;
    load = 1'b1;
    @(negedge clk);
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
    check_codes("R10 empty pulse no write");
    for (int k = 0; k < 5; k++) @(negedge clk);
    check_codes("R10 load held low");

    // R11: asynchronous reset between rising edges
    #2;
    rst_n = 1'b0;
    #1;
    model_reset();
    check_codes("R11 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_codes("R1 after reset release");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule